// File: doc/BRIEF.md
# SD Command Response Status Decoder

This block sits between a host register bus and the card-facing command engine of an SD host controller. Software writes a command word over a 16-bit register bus. If the block is enabled, it emits a one-cycle issue strobe carrying the command index and the 32-bit argument. It then waits for the card-side logic to hand back the captured response as a 16-byte vector with a received byte count. When that response arrives, the block does four things. It checks that the byte count is long enough for the response class the command asked for. It screens the card status inside the response against a per-class error mask. It updates a 16-bit host status word with a completion code. It stores the response into eight 16-bit read-back registers.

The status word is cleared by writing ones to it. A 15-bit mask selects which status bits drive a single interrupt output. The serial card signalling is outside the block.

Register words on the bus: command at address 0, argument low half at 1, argument high half at 2, configuration at 3 (bit 11 enables the block), status at 4, interrupt mask at 5, response registers 0 to 7 at addresses 8 to 15. Unlisted addresses read as zero. Response byte i of the 16-byte vector sits at `rspData[127-8i -: 8]`.

Top module: `sd_resp_status_unit`

## Requirements
- R1: After reset the status, mask, configuration, command and response registers read zero, and `irq` and `cmdIssue` are low.
- R2: A command write while configuration bit 11 is clear is ignored: no issue strobe follows, and the command register keeps its value. An accepted write stores the word and zeroes all eight response registers. In the next cycle it raises `cmdIssue` for one cycle, with `cmdIndex` equal to command bits 5:0 and `cmdArg` equal to {argument high, argument low}.
- R3: An accepted command with bit 7 set and bits 5:0 equal to zero sets status bit 0 in the next cycle, raises no issue strobe and awaits no response. A response strobe arriving while no command is waiting has no effect.
- R4: The response class is command bits 10:8. Classes 1, 3 and 6 need at least 4 received bytes, and class 2 needs 16. Command bit 11 (busy) does not change the class-1 handling. A short response sets status bit 7, clears status bits 14 and 11:0 first, and leaves the response registers at zero.
- R5: For class 1, the card status is bytes 0 to 3 taken most significant first. Any bit set under mask 0xFDF90000 sets status bit 14.
- R6: For class 6, the screened value is {byte 2, byte 3} under mask 0xE008; any hit sets status bit 14, and bytes 0 and 1 are not screened.
- R7: For class 3, response bit 31 set clears status bits 12:0. Bit 31 clear sets status bit 12.
- R8: A response with no error hit clears status bits 14 and 11:0 and keeps bits 15, 13 and 12. Class 0 and codes 4, 5 and 7 are never screened and store nothing.
- R9: A completed response without timeout sets status bits 2 and 0 for command index 12, and bit 0 alone for any other index.
- R10: After a response that passes its length check, response register k holds byte 14−2k as its high half and byte 15−2k as its low half.
- R11: Writing the status register clears each bit written as one. The mask register keeps bits 14:0. `irq` is high exactly when status and mask share a set bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Register word address |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Read data for regAddr (combinational) |
| cmdIssue | output | 1 | One-cycle command issue strobe |
| cmdIndex | output | 6 | Index of the issued command |
| cmdArg | output | 32 | Argument of the issued command |
| rspValid | input | 1 | Captured response is present |
| rspData | input | 128 | Response bytes, byte 0 in the top byte |
| rspCount | input | 5 | Number of response bytes received |
| irq | output | 1 | Interrupt, status AND mask nonzero |

## Verification
The hardest state to reach from the ports is the class-3 path, where response bit 31 wipes the low status bits. Its effect only shows if bit 12 was already set. The stimulus therefore runs two class-3 commands back to back: the first has bit 31 clear and plants bit 12, and the second has bit 31 set and must remove it. Similarly, the claim that a stray response strobe is ignored is made visible by first clearing the status word. The strobe is then sent after an init command that awaits nothing, and the status is read back as still zero.

// File: rtl/sd_resp_pkg.sv
package sd_resp_pkg;
  localparam int DATA_W    = 16;
  localparam int ADDR_W    = 4;
  localparam int RSP_WORDS = 8;
  localparam int RSP_BYTES = 2 * RSP_WORDS;
  localparam int RSP_W     = 8 * RSP_BYTES;
  localparam int CNT_W     = $clog2(RSP_BYTES + 1);

  localparam logic [ADDR_W-1:0] ADDR_CMD    = 4'd0;
  localparam logic [ADDR_W-1:0] ADDR_ARG_LO = 4'd1;
  localparam logic [ADDR_W-1:0] ADDR_ARG_HI = 4'd2;
  localparam logic [ADDR_W-1:0] ADDR_CFG    = 4'd3;
  localparam logic [ADDR_W-1:0] ADDR_STAT   = 4'd4;
  localparam logic [ADDR_W-1:0] ADDR_MASK   = 4'd5;

  localparam int CFG_ENABLE_BIT = 11;
  localparam logic [5:0] STOP_INDEX = 6'd12;

  localparam logic [31:0] CLASS1_ERR_MASK = 32'hFDF9_0000;
  localparam logic [15:0] CLASS6_ERR_MASK = 16'hE008;
  localparam logic [15:0] KEEP_ON_CLEAN   = 16'hB000;
  localparam logic [15:0] KEEP_ON_READY   = 16'hE000;
  localparam logic [15:0] BIT_ERR         = 16'h4000;
  localparam logic [15:0] BIT_BUSYCARD    = 16'h1000;
  localparam logic [15:0] BIT_TIMEOUT     = 16'h0080;
  localparam logic [15:0] CODE_DONE       = 16'h0001;
  localparam logic [15:0] CODE_STOPDONE   = 16'h0005;

  typedef enum logic [2:0] {
    RSP_NONE = 3'd0, RSP_SHORT = 3'd1, RSP_LONG = 3'd2,
    RSP_OCR  = 3'd3, RSP_ADDR  = 3'd6
  } rspClass_e;

  typedef struct packed {
    logic clrRsp;    // accepted command: zero the response registers
    logic initDone;  // init-only command completes at once
    logic decode;    // response present for a waiting command
    logic clrStat;   // write-one-to-clear on status
    logic wrMask;    // mask register write
  } ctlStrobes_t;
endpackage

// File: rtl/sd_cmd_ctrl.sv
module sd_cmd_ctrl
  import sd_resp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              rspValid,
  output ctlStrobes_t       strb,
  output logic [DATA_W-1:0] cmdWord,
  output logic [31:0]       argWord,
  output logic [DATA_W-1:0] cfgWord,
  output logic              pending,
  output logic              cmdIssue
);
  logic wrCmd, accept, initOnly;

  assign wrCmd    = regWe && (regAddr == ADDR_CMD);
  assign accept   = wrCmd && cfgWord[CFG_ENABLE_BIT];
  assign initOnly = regWrData[7] && (regWrData[5:0] == 6'd0);

  always_comb begin
    strb.clrRsp   = accept;
    strb.initDone = accept && initOnly;
    strb.decode   = rspValid && pending && !accept;
    strb.clrStat  = regWe && (regAddr == ADDR_STAT);
    strb.wrMask   = regWe && (regAddr == ADDR_MASK);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdWord  <= '0;
      argWord  <= '0;
      cfgWord  <= '0;
      pending  <= 1'b0;
      cmdIssue <= 1'b0;
    end else begin
      cmdIssue <= accept && !initOnly;
      if (accept) begin
        cmdWord <= regWrData;
        pending <= !initOnly;
      end else if (strb.decode) begin
        pending <= 1'b0;
      end
      if (regWe && regAddr == ADDR_ARG_LO) argWord[15:0]  <= regWrData;
      if (regWe && regAddr == ADDR_ARG_HI) argWord[31:16] <= regWrData;
      if (regWe && regAddr == ADDR_CFG)    cfgWord        <= regWrData;
    end
  end
endmodule

// File: rtl/sd_status_dp.sv
module sd_status_dp
  import sd_resp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strb,
  input  logic [DATA_W-1:0] cmdWord,
  input  logic [31:0]       argWord,
  input  logic [DATA_W-1:0] cfgWord,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [RSP_W-1:0]  rspData,
  input  logic [CNT_W-1:0]  rspCount,
  output logic [DATA_W-1:0] regRdData,
  output logic [DATA_W-1:0] statusWord,
  output logic [14:0]       maskWord,
  output logic              irq
);
  logic [DATA_W-1:0] rspReg [RSP_WORDS];
  logic [2:0]        rspClass;
  logic [CNT_W-1:0]  need;
  logic              screened, lenOk, timeout, storeRsp, errHit;
  logic [31:0]       cardStat;
  logic [15:0]       addrStat;
  logic [DATA_W-1:0] decStat, nextStat;

  assign rspClass = cmdWord[10:8];
  assign cardStat = rspData[RSP_W-1 -: 32];
  assign addrStat = rspData[RSP_W-17 -: 16];

  always_comb begin
    screened = (rspClass == RSP_SHORT) || (rspClass == RSP_LONG) ||
               (rspClass == RSP_OCR)   || (rspClass == RSP_ADDR);
    need     = (rspClass == RSP_LONG) ? CNT_W'(RSP_BYTES) : CNT_W'(4);
    lenOk    = rspCount >= need;
    timeout  = screened && !lenOk;
    storeRsp = screened && lenOk;
    errHit   = lenOk &&
               (((rspClass == RSP_SHORT) && |(cardStat & CLASS1_ERR_MASK)) ||
                ((rspClass == RSP_ADDR)  && |(addrStat & CLASS6_ERR_MASK)));

    decStat = statusWord;
    if (rspClass == RSP_OCR && lenOk)
      decStat = cardStat[31] ? (decStat & KEEP_ON_READY) : (decStat | BIT_BUSYCARD);
    decStat = errHit ? (decStat | BIT_ERR) : (decStat & KEEP_ON_CLEAN);
    if (timeout)                        decStat = decStat | BIT_TIMEOUT;
    else if (cmdWord[5:0] == STOP_INDEX) decStat = decStat | CODE_STOPDONE;
    else                                decStat = decStat | CODE_DONE;

    nextStat = statusWord;
    if (strb.decode)   nextStat = decStat;
    if (strb.initDone) nextStat = nextStat | CODE_DONE;
    if (strb.clrStat)  nextStat = nextStat & ~regWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusWord <= '0;
      maskWord   <= '0;
    end else begin
      statusWord <= nextStat;
      if (strb.wrMask) maskWord <= regWrData[14:0];
    end
  end

  for (genvar k = 0; k < RSP_WORDS; k++) begin : g_rsp
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                          rspReg[k] <= '0;
      else if (strb.clrRsp)               rspReg[k] <= '0;
      else if (strb.decode && storeRsp)   rspReg[k] <= rspData[16*k +: 16];
    end
  end

  assign irq = |(statusWord[14:0] & maskWord);

  always_comb begin
    regRdData = '0;
    if (regAddr[3]) regRdData = rspReg[regAddr[2:0]];
    else begin
      case (regAddr)
        ADDR_CMD:    regRdData = cmdWord;
        ADDR_ARG_LO: regRdData = argWord[15:0];
        ADDR_ARG_HI: regRdData = argWord[31:16];
        ADDR_CFG:    regRdData = cfgWord;
        ADDR_STAT:   regRdData = statusWord;
        ADDR_MASK:   regRdData = {1'b0, maskWord};
        default:     regRdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/sd_resp_status_unit.sv
module sd_resp_status_unit
  import sd_resp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              cmdIssue,
  output logic [5:0]        cmdIndex,
  output logic [31:0]       cmdArg,
  input  logic              rspValid,
  input  logic [RSP_W-1:0]  rspData,
  input  logic [CNT_W-1:0]  rspCount,
  output logic              irq
);
  ctlStrobes_t       strb;
  logic [DATA_W-1:0] cmdWord, cfgWord, statusWord;
  logic [31:0]       argWord;
  logic [14:0]       maskWord;
  logic              pending;

  sd_cmd_ctrl u_ctrl (
    .clk, .rstN, .regWe, .regAddr, .regWrData, .rspValid,
    .strb, .cmdWord, .argWord, .cfgWord, .pending, .cmdIssue
  );

  sd_status_dp u_dp (
    .clk, .rstN, .strb, .cmdWord, .argWord, .cfgWord, .regAddr, .regWrData,
    .rspData, .rspCount, .regRdData, .statusWord, .maskWord, .irq
  );

  assign cmdIndex = cmdWord[5:0];
  assign cmdArg   = argWord;
endmodule

// File: rtl/sd_resp_status_chk.sv
module sd_resp_status_chk
  import sd_resp_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWrData,
  input logic [DATA_W-1:0] regRdData,
  input logic              cmdIssue,
  input logic              rspValid,
  input logic [CNT_W-1:0]  rspCount,
  input logic              irq,
  input logic [DATA_W-1:0] cmdWord,
  input logic [DATA_W-1:0] cfgWord,
  input logic [DATA_W-1:0] statusWord,
  input logic              pending
);
  logic cmdWr, enabled;
  assign cmdWr   = regWe && regAddr == ADDR_CMD;
  assign enabled = cfgWord[CFG_ENABLE_BIT];

  assert_disabled_cmd_R2: assert property (@(posedge clk) disable iff (!rstN)
    cmdWr && !enabled |=> !cmdIssue);

  assert_rsp_cleared_R2: assert property (@(posedge clk) disable iff (!rstN)
    cmdWr && enabled |=> (!regAddr[3] || regRdData == '0));

  assert_init_only_R3: assert property (@(posedge clk) disable iff (!rstN)
    cmdWr && enabled && regWrData[7] && regWrData[5:0] == 6'd0
      |=> statusWord[0] && !cmdIssue);

  assert_short_long_timeout_R4: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && pending && !regWe && cmdWord[10:8] == 3'd2 && rspCount < CNT_W'(RSP_BYTES)
      |=> statusWord[7]);

  assert_stop_code_R9: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && pending && !regWe && cmdWord[10:8] == 3'd0 && cmdWord[5:0] == STOP_INDEX
      |=> statusWord[2] && statusWord[0]);

  assert_w1c_R11: assert property (@(posedge clk) disable iff (!rstN)
    regWe && regAddr == ADDR_STAT |=> (statusWord & $past(regWrData)) == '0);

  assert_mask_off_R11: assert property (@(posedge clk) disable iff (!rstN)
    regWe && regAddr == ADDR_MASK && regWrData == '0 |=> !irq);
endmodule

bind sd_resp_status_unit sd_resp_status_chk u_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWrData(regWrData),
  .regRdData(regRdData), .cmdIssue(cmdIssue), .rspValid(rspValid), .rspCount(rspCount),
  .irq(irq), .cmdWord(cmdWord), .cfgWord(cfgWord), .statusWord(statusWord),
  .pending(pending)
);

// File: tb/sim_sd_resp_status_unit.sv
`timescale 1ns/1ps
module sim_sd_resp_status_unit;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         regWe = 1'b0;
  logic [3:0]   regAddr = '0;
  logic [15:0]  regWrData = '0;
  logic [15:0]  regRdData;
  logic         cmdIssue;
  logic [5:0]   cmdIndex;
  logic [31:0]  cmdArg;
  logic         rspValid = 1'b0;
  logic [127:0] rspData = '0;
  logic [4:0]   rspCount = '0;
  logic         irq;

  sd_resp_status_unit u0 (
    .clk, .rstN, .regWe, .regAddr, .regWrData, .regRdData, .cmdIssue,
    .cmdIndex, .cmdArg, .rspValid, .rspData, .rspCount, .irq
  );

  always #2.5 clk = ~clk;

  localparam int K_READ = 0, K_ISSUE = 1, K_ARG = 2, K_IRQ = 3;
  typedef struct { int kind; logic [3:0] addr; logic [31:0] exp; string tag; } item_t;
  item_t scoreQ [$];
  int checks = 0, errors = 0;
  logic probeReq = 1'b0;
  logic done = 1'b0;

  // Monitor: pops one expected item per probed cycle and compares it.
  always @(negedge clk) begin
    if (probeReq && scoreQ.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = scoreQ.pop_front();
      case (it.kind)
        K_READ:  act = {16'h0, regRdData};
        K_ISSUE: act = cmdIssue ? {25'h0, 1'b1, cmdIndex} : 32'h0;
        K_ARG:   act = cmdArg;
        default: act = {31'h0, irq};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic probe(input int kind, input logic [3:0] addr, input logic [31:0] exp,
                       input string tag);
    item_t it;
    it.kind = kind; it.addr = addr; it.exp = exp; it.tag = tag;
    regAddr = addr;
    scoreQ.push_back(it);
    probeReq = 1'b1;
    @(negedge clk);
    #1 probeReq = 1'b0;
  endtask

  task automatic readChk(input logic [3:0] addr, input logic [15:0] exp, input string tag);
    probe(K_READ, addr, {16'h0, exp}, tag);
  endtask

  task automatic writeReg(input logic [3:0] addr, input logic [15:0] data);
    @(posedge clk); #1;
    regWe = 1'b1; regAddr = addr; regWrData = data;
    @(posedge clk); #1;
    regWe = 1'b0;
  endtask

  task automatic respond(input logic [127:0] data, input logic [4:0] cnt);
    @(posedge clk); #1;
    rspValid = 1'b1; rspData = data; rspCount = cnt;
    @(posedge clk); #1;
    rspValid = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    readChk(4'd4, 16'h0000, "R1 status");
    readChk(4'd5, 16'h0000, "R1 mask");
    readChk(4'd3, 16'h0000, "R1 cfg");
    readChk(4'd8, 16'h0000, "R1 rsp0");
    probe(K_IRQ, 4'd0, 32'h0, "R1 irq");
    probe(K_ISSUE, 4'd0, 32'h0, "R1 issue");

    // R2 disabled command write ignored
    writeReg(4'd0, 16'h0111);
    probe(K_ISSUE, 4'd0, 32'h0, "R2 no issue when disabled");
    readChk(4'd0, 16'h0000, "R2 cmd unchanged when disabled");

    writeReg(4'd3, 16'h0800);
    writeReg(4'd1, 16'h5678);
    writeReg(4'd2, 16'h1234);
    writeReg(4'd0, 16'h0111);
    probe(K_ISSUE, 4'd0, 32'h51, "R2 issue strobe index 17");
    probe(K_ARG, 4'd0, 32'h1234_5678, "R2 argument");
    readChk(4'd0, 16'h0111, "R2 cmd stored");
    respond(128'h00000900_11223344_55667788_99AABBCC, 5'd6);
    readChk(4'd4, 16'h0001, "R9 plain completion");
    readChk(4'd14, 16'h0900, "R10 rsp6");
    readChk(4'd12, 16'h3344, "R10 rsp4");
    readChk(4'd8, 16'hBBCC, "R10 rsp0");

    // R11 mask and W1C
    writeReg(4'd5, 16'hFFFF);
    readChk(4'd5, 16'h7FFF, "R11 mask width");
    probe(K_IRQ, 4'd0, 32'h1, "R11 irq on");
    writeReg(4'd4, 16'h0001);
    readChk(4'd4, 16'h0000, "R11 w1c");
    probe(K_IRQ, 4'd0, 32'h0, "R11 irq off");
    writeReg(4'd5, 16'h0001);

    // R5 class 1 error screening
    writeReg(4'd0, 16'h0118);
    readChk(4'd8, 16'h0000, "R2 rsp cleared by new command");
    respond(128'h80000000_0000FFFF_12345678_9ABCDEF0, 5'd6);
    readChk(4'd4, 16'h4001, "R5 class1 error");
    probe(K_IRQ, 4'd0, 32'h1, "R11 irq follows status");

    // R8 clean response with busy bit
    writeReg(4'd0, 16'h0907);
    respond(128'h00000900_00000000_00000000_00000000, 5'd4);
    readChk(4'd4, 16'h0001, "R8 clean clears error bit");

    // R4 long class short count
    writeReg(4'd0, 16'h0202);
    respond({128{1'b1}}, 5'd15);
    readChk(4'd4, 16'h0080, "R4 timeout");
    readChk(4'd8, 16'h0000, "R4 nothing stored");

    writeReg(4'd0, 16'h0202);
    respond(128'h01234567_89ABCDEF_FEDCBA98_76543210, 5'd16);
    readChk(4'd4, 16'h0001, "R4 long ok");
    readChk(4'd15, 16'h0123, "R10 rsp7");
    readChk(4'd8, 16'h3210, "R10 rsp0 long");

    // R7 class 3
    writeReg(4'd0, 16'h0301);
    respond({32'h00FF8000, 96'h0}, 5'd4);
    readChk(4'd4, 16'h1001, "R7 bit31 clear sets bit12");
    writeReg(4'd0, 16'h0301);
    respond({32'h80FF8000, 96'h0}, 5'd4);
    readChk(4'd4, 16'h0001, "R7 bit31 set clears low bits");

    // R6 class 6
    writeReg(4'd0, 16'h0603);
    respond({32'hFFFF2000, 96'h0}, 5'd4);
    readChk(4'd4, 16'h4001, "R6 error hit");
    writeReg(4'd0, 16'h0603);
    respond({32'hFFFF0500, 96'h0}, 5'd4);
    readChk(4'd4, 16'h0001, "R6 bytes 0-1 not screened");

    // R9 stop command
    writeReg(4'd0, 16'h010C);
    respond(128'h0, 5'd4);
    readChk(4'd4, 16'h0005, "R9 stop code");

    // R8 class 0 stores nothing
    writeReg(4'd4, 16'hFFFF);
    writeReg(4'd0, 16'h0005);
    respond({128{1'b1}}, 5'd16);
    readChk(4'd4, 16'h0001, "R8 class0 completion");
    readChk(4'd8, 16'h0000, "R8 class0 no store");

    // R3 init-only command and stray response
    writeReg(4'd4, 16'hFFFF);
    writeReg(4'd0, 16'h0080);
    probe(K_ISSUE, 4'd0, 32'h0, "R3 no issue");
    readChk(4'd4, 16'h0001, "R3 init sets bit0");
    writeReg(4'd4, 16'h0001);
    respond({128{1'b1}}, 5'd16);
    readChk(4'd4, 16'h0000, "R3 stray response ignored");

    // R2 disable again
    writeReg(4'd3, 16'h0000);
    writeReg(4'd0, 16'h0105);
    probe(K_ISSUE, 4'd0, 32'h0, "R2 disabled again");
    readChk(4'd0, 16'h0080, "R2 cmd kept");

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule